// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the hazard logic of a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each stage takes one clock and pipeline registers separate the stages. The block has no state of its own. From the register numbers and flags held in the pipeline registers, it decides in the same cycle where each ALU operand of the instruction in execute comes from. It also decides whether the front of the pipeline must hold for a cycle.

For each of the two ALU operands it produces a 2-bit select code. The code picks the register-file read value, the result waiting in the execute/memory register, or the result waiting in the memory/write-back register. A result computed by the ALU can be bypassed as soon as its producer has left execute, so a dependent instruction directly behind it runs at full rate. A load is different. When a load is in execute and the instruction in decode reads the load's destination, the unit raises a stall. The stall freezes the program counter and the fetch/decode register and puts a no-operation into the decode/execute register. One cycle later the loaded value reaches the memory/write-back register and is bypassed from there.

The register file writes in the first half of a cycle and reads in the second half. For that reason the write-back stage needs no bypass path of its own.

Top module: `hz_unit`

## Requirements
- R1: With no qualifying producer match, an operand select is 2'b00 (register file). The code 2'b11 is never produced.
- R2: An operand select is 2'b10 when the execute/memory register has its write flag set, its destination is non-zero and the destination equals that operand's source register.
- R3: An operand select is 2'b01 when only the memory/write-back register qualifies: write flag set, non-zero destination equal to the source register.
- R4: When both producer registers qualify for the same source register, the select is 2'b10, so the younger result wins.
- R5: A producer whose destination is register 0 never causes a bypass, even when its write flag is set.
- R6: A producer whose write flag is clear never causes a bypass.
- R7: When the instruction in execute is a load, its destination is non-zero and that destination equals either source register of the instruction in decode, stall is 1, pc_we is 0, ifid_we is 0 and idex_bubble is 1.
- R8: No stall is raised for a non-load in execute, for a load with destination 0, or for a load whose destination matches neither decode source.
- R9: While stall is 0, pc_we and ifid_we are 1 and idex_bubble is 0.
- R10: The two operand selects are decided independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_AW | First source register of the instruction in decode |
| id_rt | input | REG_AW | Second source register of the instruction in decode |
| ex_rs | input | REG_AW | First source register of the instruction in execute |
| ex_rt | input | REG_AW | Second source register of the instruction in execute |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| ex_load | input | 1 | Instruction in execute reads data memory |
| mem_dst | input | REG_AW | Destination held in the execute/memory register |
| mem_wr | input | 1 | Register-write flag in the execute/memory register |
| wb_dst | input | REG_AW | Destination held in the memory/write-back register |
| wb_wr | input | 1 | Register-write flag in the memory/write-back register |
| sel_a | output | 2 | Select for ALU operand A: 00 register file, 10 exec/mem, 01 mem/wb |
| sel_b | output | 2 | Select for ALU operand B, same encoding |
| stall | output | 1 | Load-use interlock active |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Clear decode/execute control fields to a no-operation |

## Verification
The bench targets the case where both producers name the same register. A design with the priority reversed would feed the ALU a stale, older result. It drives register 0 as a destination with the write flag set; a design that misses that guard would bypass a value that register 0 must never supply. It pairs matching destinations with cleared write flags, which catches compares that ignore the flag. It also covers loads matching either decode source, next to non-loads and loads to register 0. Here a faulty interlock would either drop the one-cycle hold or stall for no reason. The stimulus is random, drawn from a register range of four, so all of these collisions occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output opnd_src_e         sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_wr && (mem_dst != '0) && (mem_dst == src);
    wb_hit  = wb_wr  && (wb_dst  != '0) && (wb_dst  == src);
    // younger producer first (R4)
    if (mem_hit)     sel = SRC_EXMEM;
    else if (wb_hit) sel = SRC_MEMWB;
    else             sel = SRC_REGFILE;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW = 5
) (
  input  logic              ld,
  input  logic [REG_AW-1:0] ld_dst,
  input  logic [REG_AW-1:0] use_a,
  input  logic [REG_AW-1:0] use_b,
  output logic              hit
);
  always_comb begin
    hit = ld && (ld_dst != '0) && ((ld_dst == use_a) || (ld_dst == use_b));
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int REG_AW = $clog2(NREGS)
) (
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              stall,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble
);
  localparam int NOPND = 2;

  logic [REG_AW-1:0] opnd_src [NOPND];
  opnd_src_e         opnd_sel [NOPND];
  logic              lu_hit;

  assign opnd_src[0] = ex_rs;
  assign opnd_src[1] = ex_rt;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    hz_src_match #(.REG_AW(REG_AW)) u_match (
      .src    (opnd_src[g]),
      .mem_dst(mem_dst),
      .mem_wr (mem_wr),
      .wb_dst (wb_dst),
      .wb_wr  (wb_wr),
      .sel    (opnd_sel[g])
    );
  end

  hz_load_use #(.REG_AW(REG_AW)) u_lu (
    .ld    (ex_load),
    .ld_dst(ex_dst),
    .use_a (id_rs),
    .use_b (id_rt),
    .hit   (lu_hit)
  );

  always_comb begin
    sel_a       = opnd_sel[0];
    sel_b       = opnd_sel[1];
    stall       = lu_hit;
    pc_we       = !lu_hit;
    ifid_we     = !lu_hit;
    idex_bubble = lu_hit;
  end

  always_comb begin
    p_legal_sel_r1: assert (sel_a != 2'b11 && sel_b != 2'b11);
    if (ex_rs == '0) p_zero_src_r5: assert (sel_a == SRC_REGFILE);
    if (ex_rt == '0) p_zero_src_b_r5: assert (sel_b == SRC_REGFILE);
    if (!mem_wr && !wb_wr) p_no_writer_r6: assert (sel_a == SRC_REGFILE && sel_b == SRC_REGFILE);
    if (!mem_wr && sel_a != SRC_REGFILE) p_older_only_r3: assert (sel_a == SRC_MEMWB);
    if (!ex_load) p_no_load_r8: assert (!stall);
    if (stall) p_freeze_r7: assert (!pc_we && !ifid_we && idex_bubble);
    if (!stall) p_run_r9: assert (pc_we && ifid_we && !idex_bubble);
  end
endmodule

// File: tb/hz_unit_test.sv
module hz_unit_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0, ex_dst = '0;
  logic [AW-1:0] mem_dst = '0, wb_dst = '0;
  logic ex_load = 1'b0, mem_wr = 1'b0, wb_wr = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic stall, pc_we, ifid_we, idex_bubble;

  int checks = 0;
  int errors = 0;

  hz_unit uut (
    .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .ex_dst(ex_dst), .ex_load(ex_load), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .sel_a(sel_a), .sel_b(sel_b),
    .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
  );

  function automatic int exp_sel(input int s);
    bit m, w;
    m = mem_wr && mem_dst != 0 && int'(mem_dst) == s;
    w = wb_wr && wb_dst != 0 && int'(wb_dst) == s;
    if (m) return 2;
    if (w) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(input int s);
    bit mq, wq;
    mq = int'(mem_dst) == s;
    wq = int'(wb_dst) == s;
    if (s == 0 && (mq || wq)) return "R5";
    if ((mq && !mem_wr) || (wq && !wb_wr)) return "R6";
    if (mq && wq) return "R4";
    if (mq) return "R2";
    if (wq) return "R3";
    return "R1";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ls;
    ls = ex_load && ex_dst != 0 && (ex_dst == id_rs || ex_dst == id_rt);
    chk({sel_tag(int'(ex_rs)), " sel_a"}, int'(sel_a), exp_sel(int'(ex_rs)));
    chk({sel_tag(int'(ex_rt)), " sel_b R10"}, int'(sel_b), exp_sel(int'(ex_rt)));
    chk(ls ? "R7 stall" : "R8 stall", int'(stall), int'(ls));
    chk(ls ? "R7 pc_we" : "R9 pc_we", int'(pc_we), int'(!ls));
    chk(ls ? "R7 ifid_we" : "R9 ifid_we", int'(ifid_we), int'(!ls));
    chk(ls ? "R7 bubble" : "R9 bubble", int'(idex_bubble), int'(ls));
  endtask

  task automatic apply(input int irs, irt, ers, ert, ed, input bit ld,
                       input int md, input bit mw, input int wd, input bit ww);
    @(posedge clk);
    #1;
    id_rs = AW'(irs); id_rt = AW'(irt); ex_rs = AW'(ers); ex_rt = AW'(ert);
    ex_dst = AW'(ed); ex_load = ld; mem_dst = AW'(md); mem_wr = mw;
    wb_dst = AW'(wd); wb_wr = ww;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();                          // R1 R9 idle state
        apply(1, 2, 3, 4, 5, 0, 3, 1, 4, 1);    // R2 a, R3 b
        apply(1, 2, 6, 6, 5, 0, 6, 1, 6, 1);    // R4 both
        apply(1, 2, 0, 0, 5, 0, 0, 1, 0, 1);    // R5 register 0
        apply(1, 2, 7, 8, 5, 0, 7, 0, 8, 0);    // R6 write flag clear
        apply(9, 2, 1, 1, 9, 1, 0, 0, 0, 0);    // R7 load hits rs
        apply(3, 9, 1, 1, 9, 1, 0, 0, 0, 0);    // R7 load hits rt
        apply(9, 9, 1, 1, 0, 1, 0, 0, 0, 0);    // R8 load to r0
        apply(9, 9, 1, 1, 9, 0, 0, 0, 0, 0);    // R8 non-load match
        apply(4, 4, 9, 9, 9, 0, 0, 0, 9, 1);    // R3 after stall, from mem/wb
        for (int i = 0; i < 3000; i++) begin
          apply($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
                $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom));
        end
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule